// File: doc/BRIEF.md
# Two-Chain Configurable Priority Interrupt Controller

This block gathers interrupt requests from eight sources and groups them into five system interrupts, numbered 0 to 4. The number of each system interrupt is also its vector index. Each source keeps a sticky flag. A source's flag is set by a one-cycle request pulse, except for the external source, whose flag is set by a qualified edge on a pin that first passes through a synchronizer. Software clears a flag by writing a 1 to it. Every system interrupt has a priority bit that places it on either the high chain or the low chain, and software may change that bit at any time. Each chain has its own global enable. Within a chain the lowest index wins, and any request on the high chain beats every request on the low chain. The external source can be switched into a non-maskable mode. In that mode it bypasses every enable and outranks all other requests.

The CPU pulses `instr_done` at each instruction boundary. The control state machine has two states. It waits in `ST_RUN`. If `instr_done` is high and some request is eligible, it takes the transition RUN-to-GRANT and captures the winner's vector and level. In `ST_GRANT` it asserts `ack_valid` for exactly one cycle, then takes GRANT-to-RUN without condition. In any other case it stays in `ST_RUN` (transition RUN-hold). Granting a request does not clear its flag.

Top module: `dual_chain_irq_ctrl`

## Requirements
- R1: After reset, `ack_valid` is 0 and every register reads 0: enables, flags, priority bits and control bits.
- R2: Register map, selected by `reg_addr`. Address 0 holds the per-source enables (R/W, bit i is source i). Address 1 holds the flags: a read returns them, and writing a 1 to a bit clears it. Address 2 holds the priority bits [4:0] (R/W, 1 = high chain). Address 3 holds the control bits (R/W): bit0 external polarity, bit1 non-maskable mode, bit2 high-chain global enable, bit3 low-chain global enable. All four registers read back as written (the flags read back their state).
- R3: A pulse on `req_pulse[i]` sets flag i. The flag stays set until a write-1 clear. A set and a clear in the same cycle leave the flag set.
- R4: Sources map to system interrupts as follows: sources 0,1,2 to system 0; source 3 to system 1; source 4 (external) to system 2; sources 5,6 to system 3; source 7 to system 4. A system interrupt requests when any of its sources has both its flag and its enable set.
- R5: Any eligible high-chain request is granted ahead of any low-chain request. The level code is 1 for high and 0 for low.
- R6: Within one chain, the request with the lowest system index wins.
- R7: A chain's requests are eligible only while that chain's global enable bit is set.
- R8: A grant happens only in a cycle where `instr_done` is high. The grant shows as `ack_valid` high for exactly one cycle in the next cycle, together with the vector and level. The flags are left unchanged, so a later boundary grants the same source again.
- R9: The external pin passes through a two-flop synchronizer. With polarity 1, only a rising edge sets flag 4. With polarity 0, only a falling edge sets it. `req_pulse[4]` has no effect.
- R10: In non-maskable mode, a set flag 4 is granted with vector 2 and level code 2, regardless of its enable, both global enables and any other request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_pulse | input | 8 | One-cycle request pulses, one per source (bit 4 unused) |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| instr_done | input | 1 | Instruction-boundary strobe |
| ack_valid | output | 1 | Grant strobe, one cycle |
| ack_vector | output | 3 | Granted system interrupt index |
| ack_level | output | 2 | Granted level: 0 low, 1 high, 2 non-maskable |

## Verification
The bench first walks a table of enable, priority, control and request patterns. It then targets several corner cases:
- A set and a clear landing on the same flag in the same cycle: a design that let the clear win would lose the interrupt.
- The high chain against the low chain when the low index sits on the low chain: a plain index encoder would pick the wrong vector.
- A masked or globally disabled chain: a missing gate would grant anyway.
- Pin edges of the unselected polarity, and pulses on the unused request bit 4: a wrong detector would set flag 4.
- Non-maskable mode with every enable cleared while a high-chain source is also pending: the external source must still win.
- Repeated boundaries with no clear in between: an auto-clearing design would grant only once.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_SRC = 8;
    localparam int NUM_SYS = 5;
    localparam int VEC_W   = $clog2(NUM_SYS);
    localparam int DATA_W  = 8;
    localparam int EXT_SRC = 4;
    localparam int EXT_SYS = 2;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_HIGH = 2'd1,
        LVL_NMI  = 2'd2
    } lvl_e;

    // Source membership of each system interrupt
    function automatic logic [NUM_SRC-1:0] sys_src_mask(input int sys);
        case (sys)
            0:       return 8'h07;
            1:       return 8'h08;
            2:       return 8'h10;
            3:       return 8'h60;
            4:       return 8'h80;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/irq_src_flags.sv
module irq_src_flags #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] clr_eff;
    assign clr_eff = clr_we ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) flags_o <= '0;
        else        flags_o <= (flags_o & ~clr_eff) | set_i;
    end

    // R3: a set event always lands, even against a clear
    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_ext_edge.sv
module irq_ext_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic rise_sel,
    output logic edge_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    logic cur;
    assign cur    = sync_q[SYNC_STAGES-1];
    assign edge_o = rise_sel ? (cur & ~prev_q) : (~cur & prev_q);

    // R9: an edge pulse never lasts two cycles
    assert_edge_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o || $changed(rise_sel));
endmodule

// File: rtl/irq_chain_arb.sv
module irq_chain_arb
    import irq_pkg::*;
(
    input  logic [NUM_SYS-1:0] sys_req,
    input  logic [NUM_SYS-1:0] prio_hi,
    input  logic               gie_hi,
    input  logic               gie_lo,
    input  logic               nmi_req,
    output logic               win_any,
    output logic [VEC_W-1:0]   win_vec,
    output lvl_e               win_lvl,
    output logic               hi_any
);
    logic [NUM_SYS-1:0] hi_req, lo_req;
    logic [VEC_W-1:0]   hi_idx, lo_idx;

    assign hi_req = sys_req & prio_hi & {NUM_SYS{gie_hi}};
    assign lo_req = sys_req & ~prio_hi & {NUM_SYS{gie_lo}};
    assign hi_any = |hi_req;

    always_comb begin
        hi_idx = '0;
        lo_idx = '0;
        for (int i = NUM_SYS - 1; i >= 0; i--) begin
            if (hi_req[i]) hi_idx = VEC_W'(i);
            if (lo_req[i]) lo_idx = VEC_W'(i);
        end
    end

    always_comb begin
        win_any = 1'b1;
        win_vec = '0;
        win_lvl = LVL_LOW;
        if (nmi_req) begin
            win_vec = VEC_W'(EXT_SYS);
            win_lvl = LVL_NMI;
        end else if (hi_any) begin
            win_vec = hi_idx;
            win_lvl = LVL_HIGH;
        end else if (|lo_req) begin
            win_vec = lo_idx;
        end else begin
            win_any = 1'b0;
        end
    end
endmodule

// File: rtl/dual_chain_irq_ctrl.sv
module dual_chain_irq_ctrl
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_pulse,
    input  logic               ext_pin,
    input  logic               reg_we,
    input  logic [1:0]         reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               instr_done,
    output logic               ack_valid,
    output logic [VEC_W-1:0]   ack_vector,
    output logic [1:0]         ack_level
);
    typedef enum logic {ST_RUN = 1'b0, ST_GRANT = 1'b1} state_e;

    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SYS-1:0] prio_q;
    logic               pol_q, nmi_q, ghi_q, glo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            prio_q <= '0;
            pol_q  <= 1'b0;
            nmi_q  <= 1'b0;
            ghi_q  <= 1'b0;
            glo_q  <= 1'b0;
        end else if (reg_we) begin
            unique case (reg_addr)
                2'd0: en_q   <= reg_wdata[NUM_SRC-1:0];
                2'd2: prio_q <= reg_wdata[NUM_SYS-1:0];
                2'd3: {glo_q, ghi_q, nmi_q, pol_q} <= reg_wdata[3:0];
                default: ;
            endcase
        end
    end

    logic               ext_edge;
    logic [NUM_SRC-1:0] set_vec, flags;

    irq_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin_i(ext_pin), .rise_sel(pol_q), .edge_o(ext_edge)
    );

    always_comb begin
        set_vec          = req_pulse;
        set_vec[EXT_SRC] = ext_edge;
    end

    irq_src_flags #(.N(NUM_SRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec),
        .clr_we(reg_we && reg_addr == 2'd1), .clr_mask(reg_wdata[NUM_SRC-1:0]),
        .flags_o(flags)
    );

    always_comb begin
        unique case (reg_addr)
            2'd0: reg_rdata = DATA_W'(en_q);
            2'd1: reg_rdata = DATA_W'(flags);
            2'd2: reg_rdata = DATA_W'(prio_q);
            default: reg_rdata = DATA_W'({glo_q, ghi_q, nmi_q, pol_q});
        endcase
    end

    // System request formation
    logic [NUM_SRC-1:0] live;
    logic [NUM_SYS-1:0] sys_req;
    logic               nmi_req;
    assign live    = flags & en_q;
    assign nmi_req = nmi_q & flags[EXT_SRC];

    for (genvar g = 0; g < NUM_SYS; g++) begin : g_sys
        if (g == EXT_SYS) begin : g_ext
            assign sys_req[g] = ~nmi_q & (|(live & sys_src_mask(g)));
        end else begin : g_norm
            assign sys_req[g] = |(live & sys_src_mask(g));
        end
    end

    logic             win_any, hi_any;
    logic [VEC_W-1:0] win_vec;
    lvl_e             win_lvl;

    irq_chain_arb u_arb (
        .sys_req(sys_req), .prio_hi(prio_q), .gie_hi(ghi_q), .gie_lo(glo_q),
        .nmi_req(nmi_req), .win_any(win_any), .win_vec(win_vec),
        .win_lvl(win_lvl), .hi_any(hi_any)
    );

    // Control FSM
    state_e           state_q, state_d;
    logic [VEC_W-1:0] vec_q;
    lvl_e             lvl_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (instr_done && win_any) state_d = ST_GRANT;
            ST_GRANT: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
            lvl_q <= LVL_LOW;
        end else if (state_q == ST_RUN && state_d == ST_GRANT) begin
            vec_q <= win_vec;
            lvl_q <= win_lvl;
        end
    end

    always_comb begin
        ack_valid  = (state_q == ST_GRANT);
        ack_vector = ack_valid ? vec_q : '0;
        ack_level  = ack_valid ? lvl_q : LVL_LOW;
    end

    assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid);
    assert_grant_on_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_valid) |-> $past(instr_done));
    assert_nmi_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_level == LVL_NMI) |-> ack_vector == VEC_W'(EXT_SYS));
    assert_high_beats_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_valid) && ack_level == LVL_LOW |-> !$past(hi_any) && !$past(nmi_req));
endmodule

// File: tb/dual_chain_irq_ctrl_tb.sv
module dual_chain_irq_ctrl_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_pulse = '0;
    logic       ext_pin = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       instr_done = 1'b0;
    logic       ack_valid;
    logic [2:0] ack_vector;
    logic [1:0] ack_level;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_chain_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse), .ext_pin(ext_pin),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .instr_done(instr_done), .ack_valid(ack_valid),
        .ack_vector(ack_vector), .ack_level(ack_level)
    );

    typedef struct packed {
        logic [7:0] en;
        logic [4:0] pr;
        logic [3:0] ctl;
        logic [7:0] req;
        logic       v;
        logic [2:0] vec;
        logic [1:0] lvl;
    } vec_t;

    // ctl bits: 0 polarity, 1 nmi, 2 high global, 3 low global
    localparam vec_t TBL [0:10] = '{
        '{8'hFF, 5'h00, 4'hC, 8'h80, 1'b1, 3'd4, 2'd0},  // R4 R6
        '{8'hFF, 5'h00, 4'hC, 8'h81, 1'b1, 3'd0, 2'd0},  // R6
        '{8'hFF, 5'h10, 4'hC, 8'h81, 1'b1, 3'd4, 2'd1},  // R5
        '{8'hFF, 5'h08, 4'hC, 8'h68, 1'b1, 3'd3, 2'd1},  // R5
        '{8'hF7, 5'h00, 4'hC, 8'h08, 1'b0, 3'd0, 2'd0},  // R4 masked
        '{8'hFF, 5'h1F, 4'h8, 8'h01, 1'b0, 3'd0, 2'd0},  // R7
        '{8'hFF, 5'h02, 4'h4, 8'h09, 1'b1, 3'd1, 2'd1},  // R7
        '{8'h40, 5'h00, 4'hC, 8'h20, 1'b0, 3'd0, 2'd0},  // R4
        '{8'h40, 5'h00, 4'hC, 8'h40, 1'b1, 3'd3, 2'd0},  // R4
        '{8'hFF, 5'h06, 4'hC, 8'h0E, 1'b1, 3'd1, 2'd1},  // R5 R6
        '{8'hFF, 5'h00, 4'hC, 8'h10, 1'b0, 3'd0, 2'd0}   // R9 bit 4 ignored
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_req(input logic [7:0] m);
        @(negedge clk); req_pulse = m;
        @(negedge clk); req_pulse = '0;
    endtask

    // Boundary strobe; returns the ack seen in the following cycle
    task automatic boundary(output logic v, output logic [2:0] vec, output logic [1:0] lvl);
        @(negedge clk); instr_done = 1'b1;
        @(negedge clk); instr_done = 1'b0;
        v = ack_valid; vec = ack_vector; lvl = ack_level;
        @(negedge clk);
        chk("R8 valid one cycle", int'(ack_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic v;
        logic [2:0] vec;
        logic [1:0] lvl;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 ack_valid", int'(ack_valid), 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1 reg zero", int'(d), 0);
        end

        // Table walk
        foreach (TBL[k]) begin
            wr(2'd1, 8'hFF);
            wr(2'd0, TBL[k].en);
            wr(2'd2, {3'b0, TBL[k].pr});
            wr(2'd3, {4'b0, TBL[k].ctl});
            pulse_req(TBL[k].req);
            boundary(v, vec, lvl);
            chk("R4 R5 R6 R7 table valid", int'(v), int'(TBL[k].v));
            if (TBL[k].v) begin
                chk("R5 R6 table vector", int'(vec), int'(TBL[k].vec));
                chk("R5 table level", int'(lvl), int'(TBL[k].lvl));
            end
        end
        rd(2'd1, d);
        chk("R9 req bit4 leaves flag clear", int'(d[4]), 0);

        // R2 read back
        wr(2'd0, 8'hA5); wr(2'd2, 8'h15); wr(2'd3, 8'h0B);
        rd(2'd0, d); chk("R2 enable readback", int'(d), 'hA5);
        rd(2'd2, d); chk("R2 prio readback", int'(d), 'h15);
        rd(2'd3, d); chk("R2 ctrl readback", int'(d), 'h0B);

        // R3 flags sticky, write-1 clear, set beats clear
        wr(2'd1, 8'hFF);
        pulse_req(8'h21);
        repeat (3) @(negedge clk);
        rd(2'd1, d); chk("R3 flags held", int'(d), 'h21);
        wr(2'd1, 8'h01);
        rd(2'd1, d); chk("R3 write-1 clear", int'(d), 'h20);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h22; req_pulse = 8'h02;
        @(negedge clk);
        reg_we = 1'b0; req_pulse = '0;
        rd(2'd1, d); chk("R3 set wins over clear", int'(d), 'h02);

        // R8 no grant without boundary, no auto clear
        wr(2'd0, 8'hFF); wr(2'd2, 8'h00); wr(2'd3, 8'h0C);
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            chk("R8 no grant without instr_done", int'(ack_valid), 0);
        end
        boundary(v, vec, lvl);
        chk("R8 first grant", int'(v), 1);
        chk("R8 first vector", int'(vec), 0);
        boundary(v, vec, lvl);
        chk("R8 repeat grant (flag kept)", int'(v), 1);
        chk("R8 repeat vector", int'(vec), 0);

        // R9 external edges
        wr(2'd1, 8'hFF);
        wr(2'd3, 8'h0D);                 // rising
        @(negedge clk); ext_pin = 1'b1;
        repeat (4) @(negedge clk);
        rd(2'd1, d); chk("R9 rising edge sets flag", int'(d[4]), 1);
        boundary(v, vec, lvl);
        chk("R9 ext vector", int'(vec), 2);
        wr(2'd1, 8'hFF);
        @(negedge clk); ext_pin = 1'b0;  // falling, polarity rising
        repeat (4) @(negedge clk);
        rd(2'd1, d); chk("R9 falling ignored when rising selected", int'(d[4]), 0);
        wr(2'd3, 8'h0C);                 // falling polarity
        @(negedge clk); ext_pin = 1'b1;
        repeat (4) @(negedge clk);
        rd(2'd1, d); chk("R9 rising ignored when falling selected", int'(d[4]), 0);
        @(negedge clk); ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd1, d); chk("R9 falling edge sets flag", int'(d[4]), 1);

        // R10 non-maskable: flag 4 set, add high-chain source 0
        wr(2'd2, 8'h01); wr(2'd3, 8'h0E);
        pulse_req(8'h01);
        boundary(v, vec, lvl);
        chk("R10 nmi beats high chain", int'(v), 1);
        chk("R10 nmi vector", int'(vec), 2);
        chk("R10 nmi level", int'(lvl), 2);
        wr(2'd0, 8'h00); wr(2'd3, 8'h02);
        boundary(v, vec, lvl);
        chk("R10 nmi ignores all enables", int'(v), 1);
        chk("R10 nmi level masked", int'(lvl), 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule